// File: doc/BRIEF.md
# Embedded Key Authenticator

This memory-mapped peripheral holds a 256-bit secret fixed at elaboration time and answers one question: does the candidate key that a host has just written match that secret? The host writes the candidate as eight 32-bit words through an AXI4-Lite slave port. It then sets the start bit in the control register, waits for the done flag, and reads a one-bit verdict. The secret is never reachable through any register.

The comparison walks the key one 8-bit chunk per cycle through a short pipeline. A mismatch flag is ORed across every chunk, so the run always takes the same number of cycles and never stops early, whatever the key data. The store keeps a written flag for each candidate byte. A run that starts while any byte is missing returns a verdict of 0, and every completed run clears the written flags.

Top module: `key_auth`

## Requirements
- R1: After reset, the control register reads 0x4 (idle set, busy and done clear), the verdict reads 0, and no write response or read data is pending.
- R2: Each accepted write gets an OKAY response (bresp = 0) that stays valid until bready. Each accepted read returns OKAY data that stays valid and stable until rready.
- R3: A write at byte offset 0x080 + 4*i (i = 0..7) stores candidate bits [32*i+31 : 32*i]. Only the bytes whose write strobe is set change, and only those bytes are marked as written.
- R4: Writing a word with bit 0 set and strobe 0 set to offset 0x000 while idle starts a run. Writing bit 0 as 0 starts nothing. Once the run completes, bit 0 of offset 0x100 reads 1 exactly when every candidate byte was written and the candidate equals the secret.
- R5: The run completes 34 clock edges after the edge that accepts the start write. A control read accepted at edge 34 still shows busy (0x1). A control read accepted at edge 35 shows done and idle (0x6). This timing is the same for matching and mismatching keys, wherever the first difference lies.
- R6: A candidate that differs from the secret in any single bit gives a verdict of 0.
- R7: If any candidate byte has not been written since the last completed run, the verdict is 0. A completed run clears all written flags.
- R8: Control bit 1 (done) is set when a run completes and cleared by a read of the control register. Control bit 2 (idle) is 1 whenever no run is in progress. Control bit 0 reads 1 while a run is in progress.
- R9: A start request that arrives during a run is ignored. The current run neither restarts nor stretches.
- R10: Key-window writes that arrive during a run are ignored and do not affect that run's verdict.
- R11: The verdict reads 0 from the start of a run until it completes. After that it holds its value until the next start.
- R12: Reads of the key window and of unmapped offsets return 0, so the secret and the candidate cannot be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_awaddr | input | 9 | Write address (byte offset) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 9 | Read address (byte offset) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The bench flips every one of the 256 key bits in turn. A comparator that skipped a chunk, or that sampled the candidate at the wrong chunk index, would accept one of those keys. For each of the 32 bytes, the bench also leaves that byte unwritten and then patches it with a single-strobe write that carries garbage in the other lanes. This catches a store that ignores strobes or marks whole words, and a missing-byte check that a design could drop. Control reads accepted at exactly the 34th and 35th edge after start expose a latency that depends on where the first mismatch lies, or that is off by one. A second start and a stray key write issued mid-run expose a run that restarts or a candidate that changes under the comparator.

// File: rtl/key_auth_pkg.sv
// Shared register offsets and control bit positions for the key authenticator.
// Assumes byte addressing on a 32-bit data bus.
package key_auth_pkg;
    localparam int unsigned CTRL_OFFSET    = 'h000;
    localparam int unsigned KEY_OFFSET     = 'h080;
    localparam int unsigned VERDICT_OFFSET = 'h100;

    localparam int unsigned CTRL_BUSY_BIT = 0;
    localparam int unsigned CTRL_DONE_BIT = 1;
    localparam int unsigned CTRL_IDLE_BIT = 2;

    localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/key_auth_cmp.sv
// Sequential constant-time comparator. It walks the candidate against SECRET
// one chunk per cycle through a two-stage pipeline and ORs mismatches into a
// sticky flag. The run lasts NCHUNK+2 cycles regardless of data.
// Assumes start_i is only raised while idle and that cand_i is held stable
// during a run.
module key_auth_cmp #(
    parameter int KEY_W   = 256,
    parameter int CHUNK_W = 8,
    parameter logic [KEY_W-1:0] SECRET = '0,
    localparam int NCHUNK = KEY_W / CHUNK_W,
    localparam int LAT    = NCHUNK + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KEY_W-1:0] cand_i,
    input  logic             full_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             match_o
);
    localparam int CNT_W = $clog2(LAT);
    localparam int IDX_W = $clog2(NCHUNK);

    logic [NCHUNK-1:0] chunk_diff;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q, v_q, diff_q, acc_q, full_q;

    // Per-chunk inequality against the embedded secret
    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        assign chunk_diff[c] = |(cand_i[c*CHUNK_W +: CHUNK_W] ^ SECRET[c*CHUNK_W +: CHUNK_W]);
    end

    // Run sequencer: chunk select stage, mismatch accumulate stage, end count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            v_q    <= 1'b0;
            diff_q <= 1'b0;
            acc_q  <= 1'b0;
            full_q <= 1'b0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            v_q    <= 1'b0;
            diff_q <= 1'b0;
            acc_q  <= 1'b0;
            full_q <= full_i;
        end else if (busy_q) begin
            v_q    <= (cnt_q < CNT_W'(NCHUNK));
            diff_q <= chunk_diff[cnt_q[IDX_W-1:0]];
            acc_q  <= acc_q | (v_q & diff_q);
            if (cnt_q == CNT_W'(LAT - 1)) busy_q <= 1'b0;
            else                          cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy_o  = busy_q;
    assign done_o  = busy_q && (cnt_q == CNT_W'(LAT - 1));
    assign match_o = full_q & ~acc_q;

    // R9: the register file must never launch a run on top of a live one
    p_start_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q);
    // R5: a completion is a single pulse that ends the run
    p_done_ends_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o && !done_o);
endmodule

// File: rtl/key_auth_store.sv
// Candidate key store with one written flag per byte. Byte strobes select the
// lanes that update. clr_i wipes every written flag but keeps the key bits.
// Assumes we_i and clr_i never coincide (writes are blocked during a run).
module key_auth_store #(
    parameter int KEY_W  = 256,
    parameter int DATA_W = 32,
    localparam int NWORDS = KEY_W / DATA_W,
    localparam int BPW    = DATA_W / 8,
    localparam int NBYTES = KEY_W / 8,
    localparam int IDX_W  = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [BPW-1:0]    wstrb_i,
    input  logic              clr_i,
    output logic [KEY_W-1:0]  cand_o,
    output logic              full_o
);
    logic [KEY_W-1:0]  cand_q;
    logic [NBYTES-1:0] mask_q;

    // Byte-lane updates of key bits and written flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            mask_q <= '0;
        end else begin
            if (clr_i) mask_q <= '0;
            if (we_i) begin
                for (int b = 0; b < BPW; b++) begin
                    if (wstrb_i[b]) begin
                        cand_q[(int'(idx_i)*BPW + b)*8 +: 8] <= wdata_i[b*8 +: 8];
                        mask_q[int'(idx_i)*BPW + b]          <= 1'b1;
                    end
                end
            end
        end
    end

    assign cand_o = cand_q;
    assign full_o = &mask_q;

    // R7: completion wipes the written flags
    p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_q == '0));
    // R3: a write with no strobes leaves the flags alone
    p_no_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wstrb_i == '0 && !clr_i) |=> $stable(mask_q));
endmodule

// File: rtl/key_auth_regs.sv
// AXI4-Lite slave front end. It decodes the control, key window and verdict
// offsets, raises the start pulse, and holds the sticky done flag and the
// verdict. Assumes single-beat, non-overlapping transactions and responds
// OKAY to every access.
module key_auth_regs
    import key_auth_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32,
    parameter int NWORDS = 8,
    localparam int IDX_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic              wdata0,
    input  logic              wstrb0,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              match_i,
    output logic              key_we_o,
    output logic [IDX_W-1:0]  key_idx_o,
    output logic              start_o
);
    logic              bvalid_q, rvalid_q, done_q, verdict_q;
    logic [DATA_W-1:0] rdata_q, rd_word;
    logic [ADDR_W-1:0] w_off, r_off;
    logic              wr_fire, rd_fire, w_ctrl, w_key, r_ctrl, r_key, r_verd;

    // Address decode for both channels
    always_comb begin
        w_off  = awaddr - ADDR_W'(KEY_OFFSET);
        r_off  = araddr - ADDR_W'(KEY_OFFSET);
        w_ctrl = (awaddr == ADDR_W'(CTRL_OFFSET));
        w_key  = (w_off[1:0] == 2'b00) && (w_off[ADDR_W-1:2] < (ADDR_W-2)'(NWORDS));
        r_ctrl = (araddr == ADDR_W'(CTRL_OFFSET));
        r_key  = (r_off[1:0] == 2'b00) && (r_off[ADDR_W-1:2] < (ADDR_W-2)'(NWORDS));
        r_verd = (araddr == ADDR_W'(VERDICT_OFFSET));
    end

    assign wr_fire   = awvalid && wvalid && !bvalid_q;
    assign rd_fire   = arvalid && !rvalid_q;
    assign awready   = wr_fire;
    assign wready    = wr_fire;
    assign arready   = !rvalid_q;
    assign key_we_o  = wr_fire && w_key && !busy_i;
    assign key_idx_o = w_off[IDX_W+1:2];
    assign start_o   = wr_fire && w_ctrl && wstrb0 && wdata0 && !busy_i;

    // Read data mux; key window and unmapped offsets read as zero
    always_comb begin
        rd_word = '0;
        if (r_ctrl) begin
            rd_word[CTRL_BUSY_BIT] = busy_i;
            rd_word[CTRL_DONE_BIT] = done_q;
            rd_word[CTRL_IDLE_BIT] = !busy_i;
        end else if (r_verd) begin
            rd_word[0] = verdict_q;
        end else if (r_key) begin
            rd_word = '0;
        end
    end

    // Response channel state, sticky done flag, and verdict register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid_q  <= 1'b0;
            rvalid_q  <= 1'b0;
            rdata_q   <= '0;
            done_q    <= 1'b0;
            verdict_q <= 1'b0;
        end else begin
            if (wr_fire)                 bvalid_q <= 1'b1;
            else if (bready)             bvalid_q <= 1'b0;
            if (rd_fire) begin
                rvalid_q <= 1'b1;
                rdata_q  <= rd_word;
            end else if (rready) begin
                rvalid_q <= 1'b0;
            end
            if (done_i)                  done_q <= 1'b1;
            else if (rd_fire && r_ctrl)  done_q <= 1'b0;
            if (start_o)                 verdict_q <= 1'b0;
            else if (done_i)             verdict_q <= match_i;
        end
    end

    assign bvalid = bvalid_q;
    assign bresp  = RESP_OKAY;
    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
    assign rresp  = RESP_OKAY;

    // R2: a pending write response survives until taken
    p_bvalid_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid_q && !bready) |=> bvalid_q);
    // R2: pending read data stays put until taken
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_q && !rready) |=> (rvalid_q && $stable(rdata_q)));
    // R11: verdict changes only at a start or a completion
    p_verdict_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_o && !done_i) |=> $stable(verdict_q));
    // R8: completion always leaves done visible
    p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> done_q);
endmodule

// File: rtl/key_auth.sv
// Top level of the key authenticator: register file, candidate store and
// constant-time comparator. SECRET is fixed at elaboration and is wired
// only into the comparator.
module key_auth #(
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 32,
    parameter int KEY_W   = 256,
    parameter int CHUNK_W = 8,
    parameter logic [KEY_W-1:0] SECRET =
        256'h6d2e_91c4_07ab_f358_c1e0_4a97_3b62_d8f5_a4c7_1e09_5b3d_82f6_e913_7ac0_4d58_b26f
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready
);
    localparam int NWORDS = KEY_W / DATA_W;
    localparam int IDX_W  = $clog2(NWORDS);
    localparam int LAT    = KEY_W / CHUNK_W + 2;
    localparam int LCNT_W = $clog2(LAT + 1);

    logic             key_we, start, busy, done, match, full;
    logic [IDX_W-1:0] key_idx;
    logic [KEY_W-1:0] cand;

    key_auth_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWORDS(NWORDS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata0(s_wdata[0]), .wstrb0(s_wstrb[0]), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .busy_i(busy), .done_i(done), .match_i(match),
        .key_we_o(key_we), .key_idx_o(key_idx), .start_o(start)
    );

    key_auth_store #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we_i(key_we), .idx_i(key_idx), .wdata_i(s_wdata), .wstrb_i(s_wstrb),
        .clr_i(done), .cand_o(cand), .full_o(full)
    );

    key_auth_cmp #(.KEY_W(KEY_W), .CHUNK_W(CHUNK_W), .SECRET(SECRET)) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .cand_i(cand), .full_i(full),
        .busy_o(busy), .done_o(done), .match_o(match)
    );

    // Independent cycle count since the last start, used only by the latency check
    logic [LCNT_W-1:0] since_start_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                             since_start_q <= '0;
        else if (start)                         since_start_q <= '0;
        else if (since_start_q != LCNT_W'(LAT)) since_start_q <= since_start_q + 1'b1;
    end

    // R5: completion falls exactly LAT-1 cycles after the start cycle
    p_fixed_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_start_q == LCNT_W'(LAT - 1)));
    // R7: an incomplete candidate can never match
    p_partial_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !full) |=> !match);
    // R10: the candidate store never takes a write during a run
    p_no_key_write_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !key_we);
endmodule

// File: tb/test_key_auth.sv
module test_key_auth;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 256;
    localparam logic [KEY_W-1:0] SECRET =
        256'h3c9a_51e7_0bd2_8f46_a1e5_7c30_94bb_62d8_e07f_1a29_c5d3_b846_5f01_9e7a_2dc4_8b63;
    localparam logic [8:0] A_CTRL = 9'h000;
    localparam logic [8:0] A_KEY  = 9'h080;
    localparam logic [8:0] A_VERD = 9'h100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
    logic awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic bready = 1'b1, rready = 1'b1;
    logic [DATA_W-1:0] wdata = '0;
    logic [3:0] wstrb = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0] bresp, rresp;
    logic [DATA_W-1:0] rdata;

    int n_checks = 0, n_fail = 0;

    key_auth #(.SECRET(SECRET)) i_key_auth (
        .clk(clk), .rst_n(rst_n),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write, accepted at the next edge; returns just after the edge that follows
    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        awaddr = a; wdata = d; wstrb = s; awvalid = 1'b1; wvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        @(posedge clk);
    endtask

    // Read, accepted at the next edge; returns just after the edge that follows
    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        arvalid = 1'b0; d = rdata;
        @(posedge clk);
    endtask

    // Load the key; bytes set in skip are left out of the strobes
    task automatic load_key(input logic [KEY_W-1:0] k, input logic [31:0] skip);
        for (int w = 0; w < 8; w++)
            wr(A_KEY + 9'(4*w), k[32*w +: 32], ~skip[4*w +: 4]);
    endtask

    task automatic run(output logic [31:0] verdict);
        logic [31:0] c;
        wr(A_CTRL, 32'h1, 4'h1);
        repeat (40) @(posedge clk);
        rd(A_CTRL, c);
        rd(A_VERD, verdict);
    endtask

    // Start, then read control accepted exactly n edges after the start edge
    task automatic probe(input int n, output logic [31:0] c);
        logic [31:0] t;
        wr(A_CTRL, 32'h1, 4'h1);
        repeat (n - 2) @(posedge clk);
        rd(A_CTRL, c);
        repeat (40) @(posedge clk);
        rd(A_CTRL, t);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] v, c;
        logic [KEY_W-1:0] k;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 bvalid", {31'b0, bvalid}, 0);
        chk("R1 rvalid", {31'b0, rvalid}, 0);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'h4);
        rd(A_VERD, v); chk("R1 verdict", v, 0);

        // R12: no readback of key window or unmapped space
        load_key(SECRET, 0);
        for (int w = 0; w < 8; w++) begin
            rd(A_KEY + 9'(4*w), v); chk("R12 key window read", v, 0);
        end
        rd(9'h104, v); chk("R12 unmapped read", v, 0);

        // R4 / R3: a full correct key matches; start bit 0 written as 0 does nothing
        wr(A_CTRL, 32'h0, 4'hf);
        repeat (3) @(posedge clk);
        rd(A_CTRL, v); chk("R4 no start on bit0=0", v, 32'h4);
        run(v); chk("R4 correct key", v, 1);
        // R8: done cleared by the control read inside run
        rd(A_CTRL, v); chk("R8 done cleared by read", v, 32'h4);
        // R11: verdict holds while idle
        repeat (20) @(posedge clk);
        rd(A_VERD, v); chk("R11 verdict holds", v, 1);

        // R7: rerun without reloading fails because the flags were cleared
        run(v); chk("R7 rerun after clear", v, 0);

        // R5: exact latency for matching, first-chunk and last-chunk mismatch
        for (int m = 0; m < 3; m++) begin
            k = SECRET;
            if (m == 1) k[0] = ~k[0];
            if (m == 2) k[KEY_W-1] = ~k[KEY_W-1];
            load_key(k, 0); probe(34, c); chk("R5 busy at edge 34", c, 32'h1);
            load_key(k, 0); probe(35, c); chk("R5 done at edge 35", c, 32'h6);
            rd(A_VERD, v); chk("R5 verdict", v, (m == 0) ? 1 : 0);
        end

        // R6: every single-bit flip is rejected
        for (int b = 0; b < KEY_W; b++) begin
            k = SECRET; k[b] = ~k[b];
            load_key(k, 0); run(v); chk("R6 bit flip", v, 0);
        end

        // R7 / R3: each missing byte rejects; a single-strobe patch completes it
        for (int j = 0; j < 32; j++) begin
            load_key(SECRET, 32'(1) << j); run(v); chk("R7 missing byte", v, 0);
            load_key(SECRET, 32'(1) << j);
            wr(A_KEY + 9'(4*(j/4)), ~SECRET[32*(j/4) +: 32] ^ ({24'h0, SECRET[8*j +: 8]} << (8*(j%4)))
                                     ^ ({24'h0, ~SECRET[8*j +: 8]} << (8*(j%4))),
               4'(1) << (j%4));
            run(v); chk("R3 strobe patch", v, 1);
        end

        // R9 / R10 / R11: second start and key write during a run are ignored
        load_key(SECRET, 0);
        wr(A_CTRL, 32'h1, 4'h1);            // start at E0, returns after E1
        rd(A_VERD, v); chk("R11 verdict cleared mid-run", v, 0);  // accepted E2, returns after E3
        repeat (6) @(posedge clk);          // after E9
        wr(A_CTRL, 32'h1, 4'h1);            // accepted E10, returns after E11
        wr(A_KEY, 32'hdead_beef, 4'hf);     // accepted E12, returns after E13
        repeat (21) @(posedge clk);         // after E34
        rd(A_CTRL, c); chk("R9 no restart", c, 32'h6);            // accepted E35
        rd(A_VERD, v); chk("R10 write ignored", v, 1);

        // R2: responses held while ready is low
        @(negedge clk);
        bready = 1'b0;
        awaddr = 9'h104; wdata = 0; wstrb = 4'hf; awvalid = 1'b1; wvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 bvalid held", {31'b0, bvalid}, 1);
        chk("R2 bresp okay", {30'b0, bresp}, 0);
        bready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 bvalid released", {31'b0, bvalid}, 0);
        rready = 1'b0;
        araddr = A_CTRL; arvalid = 1'b1;
        @(posedge clk); @(negedge clk);
        arvalid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 rvalid held", {31'b0, rvalid}, 1);
        chk("R2 rdata stable", rdata, 32'h4);
        chk("R2 rresp okay", {30'b0, rresp}, 0);
        rready = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R2 rvalid released", {31'b0, rvalid}, 0);

        summary();
    end
endmodule